// File: doc/BRIEF.md
# Narrow-to-Wide Register Access Bridge

This block sits between a host that issues byte, halfword and dword register accesses and a register file that only accepts whole, dword-aligned 32-bit transfers. Narrow reads fetch the aligned dword and return only the addressed lane, zero-extended. Narrow writes become a read of the dword, a merge of the new lane and a write of the result.

Two halfword pairs need special handling, because splitting them into separate dword writes would corrupt the target. The first pair is the transfer-mode/command dword. The second is the block size/count dword. Writes to transfer mode, block size and block count are held in two shadow dwords and do not reach the target. A later halfword write to the command lane releases them in a fixed order. The block dword goes out first, then the command dword merged with the held transfer mode. Each pair therefore reaches the target as one 32-bit write.

Both the host and the target use a request/ready handshake. The host holds its request until the bridge pulses ready once. The target accepts one transfer per acknowledge.

Top module: `rnb_bridge`

## Requirements
- R1: After reset, `h_ready_o` and `t_req_o` are low and neither shadow is valid, so a halfword read of transfer mode is served by one target read.
- R2: Every target access uses an address with bits [1:0] equal to zero. The lane offset is (address bits [1:0]) × 8 for bytes and (address bit 1) × 16 for halfwords.
- R3: Reads that no valid shadow covers perform one target read and never a target write. Sizes are `h_size_i` 0 = byte, 1 = halfword, 2 = dword. The addressed lane is returned in the low bits of `h_rdata_o`, zero-extended.
- R4: A byte write, or a halfword write outside the shadowed dwords, performs one target read and then one target write. Only the addressed lane of that dword changes.
- R5: A dword write performs exactly one target write of the host data with no target read. It leaves both shadows unchanged.
- R6: A halfword write at offset 0 of the dword at `XFER_ADDR` (transfer mode) reads the target dword and merges the lane into the command shadow. It marks that shadow valid and writes nothing to the target. While the shadow is valid, a halfword read of transfer mode returns the held lane with no target access.
- R7: A halfword write to either lane of the dword at `BLK_ADDR` (size at bit 0, count at bit 16) merges into the block shadow. The target dword is read first only when the block shadow is not yet valid, and nothing is written to the target. While the shadow is valid, halfword reads of either lane return the held value.
- R8: A halfword write at offset 2 of `XFER_ADDR` (command) first writes a pending block shadow to `BLK_ADDR`. It then writes the command shadow, with the new command lane merged in, to `XFER_ADDR`. Both shadows are then no longer valid.
- R9: A dword read of a shadowed dword returns the target's value, not the shadow.
- R10: `h_ready_o` is high for exactly one cycle per access, after all target transfers of that access. `t_req_o` is only high while a host request is held. The target address stays stable until `t_ack_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_req_i | input | 1 | Host request, held until `h_ready_o` |
| h_we_i | input | 1 | Host write (1) or read (0) |
| h_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 dword |
| h_addr_i | input | AW | Host byte address |
| h_wdata_i | input | 32 | Host write data, lane in low bits |
| h_rdata_o | output | 32 | Host read data, zero-extended lane |
| h_ready_o | output | 1 | One-cycle completion pulse |
| t_req_o | output | 1 | Target request, held until `t_ack_i` |
| t_we_o | output | 1 | Target write (1) or read (0) |
| t_addr_o | output | AW | Target dword-aligned address |
| t_wdata_o | output | 32 | Target write data |
| t_rdata_i | input | 32 | Target read data, valid with `t_ack_i` |
| t_ack_i | input | 1 | Target acknowledge |

## Verification
The tests are directed and use three access patterns: dword, byte and halfword. Together these separate the pass-through path, the lane extraction/merge path and the shadow path. Lane tests place a distinct value in every byte, so a wrong shift or mask shows as a wrong byte.

The shadow sequences count target reads and writes per access. They also log the address and data of each target write, which exposes four faults: a premature target write, a missing fetch, a flush in the wrong order, and a flag that is not cleared. Each shadow sequence ends with dword writes to and reads of a shadowed dword while a shadow is pending. These show that the pass-through path and the shadow are independent.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int SL_CMD = 0;
  localparam int SL_BLK = 1;
  localparam int NSL = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_RD, S_BLK, S_WR, S_RESP
  } state_e;

  typedef enum logic [3:0] {
    K_RD_SH_CMD,
    K_RD_SH_BLK,
    K_RD_TGT,
    K_WR_FULL,
    K_WR_XFER,
    K_WR_BLK_SH,
    K_WR_BLK_TGT,
    K_WR_CMD,
    K_WR_RMW
  } kind_e;
endpackage

// File: rtl/rnb_lane.sv
module rnb_lane
  import rnb_pkg::*;
(
  input  size_e           size_i,
  input  logic [1:0]      ofs_i,
  input  logic [DW-1:0]   base_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   merged_o,
  output logic [DW-1:0]   extract_o
);
  logic [1:0]    lane0;
  logic [4:0]    shamt;
  logic [DW-1:0] wsh;
  logic [DW-1:0] bsh;
  logic [NB-1:0] be;

  assign lane0 = (size_i == SZ_HALF) ? {ofs_i[1], 1'b0} : ofs_i;
  assign shamt = {lane0, 3'b000};
  assign wsh   = wdata_i << shamt;
  assign bsh   = base_i >> shamt;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: be[i] = (lane0 == 2'(i));
        SZ_HALF: be[i] = (ofs_i[1] == 1'(i / 2));
        default: be[i] = 1'b1;
      endcase
    end
    assign merged_o[i*8 +: 8] = be[i] ? wsh[i*8 +: 8] : base_i[i*8 +: 8];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: extract_o = {24'h0, bsh[7:0]};
      SZ_HALF: extract_o = {16'h0, bsh[15:0]};
      default: extract_o = base_i;
    endcase
  end
endmodule

// File: rtl/rnb_slot.sv
module rnb_slot #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else if (ld_i) begin
      q_o   <= d_i;
      vld_o <= 1'b1;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rnb_bridge.sv
module rnb_bridge
  import rnb_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] XFER_ADDR = AW'('h0C),
  parameter logic [AW-1:0] BLK_ADDR  = AW'('h04)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [1:0]    h_size_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  output logic          h_ready_o,
  output logic          t_req_o,
  output logic          t_we_o,
  output logic [AW-1:0] t_addr_o,
  output logic [DW-1:0] t_wdata_o,
  input  logic [DW-1:0] t_rdata_i,
  input  logic          t_ack_i
);
  state_e        state_q;
  kind_e         kind_q, kind_d;
  size_e         op_size_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_wdata_q, merged_q, rdata_q;

  logic [NSL-1:0] sl_ld, sl_clr, sl_vld;
  logic [DW-1:0]  sl_q [NSL];
  logic           cmd_vld, blk_vld;

  logic [DW-1:0] lane_base, lane_merged, lane_extract;

  // host-side decode
  logic [AW-1:0] h_dw;
  logic          h_half, h_word, xfer_hit, cmd_hit, blk_hit;
  assign h_dw     = {h_addr_i[AW-1:2], 2'b00};
  assign h_half   = (h_size_i == 2'd1);
  assign h_word   = h_size_i[1];
  assign xfer_hit = h_half && (h_dw == XFER_ADDR) && !h_addr_i[1];
  assign cmd_hit  = h_half && (h_dw == XFER_ADDR) &&  h_addr_i[1];
  assign blk_hit  = h_half && (h_dw == BLK_ADDR);
  assign cmd_vld  = sl_vld[SL_CMD];
  assign blk_vld  = sl_vld[SL_BLK];

  always_comb begin
    if (!h_we_i) begin
      if (xfer_hit && cmd_vld)      kind_d = K_RD_SH_CMD;
      else if (blk_hit && blk_vld)  kind_d = K_RD_SH_BLK;
      else                          kind_d = K_RD_TGT;
    end else begin
      if (h_word)                   kind_d = K_WR_FULL;
      else if (xfer_hit)            kind_d = K_WR_XFER;
      else if (blk_hit)             kind_d = blk_vld ? K_WR_BLK_SH : K_WR_BLK_TGT;
      else if (cmd_hit)             kind_d = K_WR_CMD;
      else                          kind_d = K_WR_RMW;
    end
  end

  // merge base: target data during a fetch, otherwise the relevant shadow
  always_comb begin
    if (state_q == S_RD)
      lane_base = t_rdata_i;
    else if (kind_q == K_RD_SH_BLK || kind_q == K_WR_BLK_SH)
      lane_base = sl_q[SL_BLK];
    else
      lane_base = sl_q[SL_CMD];
  end

  rnb_lane u_lane (
    .size_i    (op_size_q),
    .ofs_i     (op_addr_q[1:0]),
    .base_i    (lane_base),
    .wdata_i   (op_wdata_q),
    .merged_o  (lane_merged),
    .extract_o (lane_extract)
  );

  logic rd_done, blk_done;
  assign rd_done  = (state_q == S_RD)  && t_ack_i;
  assign blk_done = (state_q == S_BLK) && t_ack_i;

  always_comb begin
    sl_ld          = '0;
    sl_clr         = '0;
    sl_ld[SL_CMD]  = rd_done && (kind_q == K_WR_XFER);
    sl_ld[SL_BLK]  = ((state_q == S_DEC) && (kind_q == K_WR_BLK_SH)) ||
                     (rd_done && (kind_q == K_WR_BLK_TGT));
    sl_clr[SL_BLK] = blk_done;
    sl_clr[SL_CMD] = blk_done ||
                     ((state_q == S_DEC) && (kind_q == K_WR_CMD) && !blk_vld);
  end

  for (genvar s = 0; s < NSL; s++) begin : g_slot
    rnb_slot #(.W(DW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (sl_ld[s]),
      .clr_i  (sl_clr[s]),
      .d_i    (lane_merged),
      .q_o    (sl_q[s]),
      .vld_o  (sl_vld[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      kind_q     <= K_RD_TGT;
      op_size_q  <= SZ_BYTE;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      merged_q   <= '0;
      rdata_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (h_req_i) begin
          kind_q     <= kind_d;
          op_size_q  <= size_e'(h_size_i);
          op_addr_q  <= h_addr_i;
          op_wdata_q <= h_wdata_i;
          state_q    <= S_DEC;
        end
        S_DEC: begin
          unique case (kind_q)
            K_RD_SH_CMD, K_RD_SH_BLK: begin
              rdata_q <= lane_extract;
              state_q <= S_RESP;
            end
            K_WR_FULL: begin
              merged_q <= op_wdata_q;
              state_q  <= S_WR;
            end
            K_WR_BLK_SH: state_q <= S_RESP;
            K_WR_CMD: begin
              if (blk_vld) state_q <= S_BLK;
              else begin
                merged_q <= lane_merged;
                state_q  <= S_WR;
              end
            end
            default: state_q <= S_RD;
          endcase
        end
        S_RD: if (t_ack_i) begin
          unique case (kind_q)
            K_WR_RMW: begin
              merged_q <= lane_merged;
              state_q  <= S_WR;
            end
            K_WR_XFER, K_WR_BLK_TGT: state_q <= S_RESP;
            default: begin
              rdata_q <= lane_extract;
              state_q <= S_RESP;
            end
          endcase
        end
        S_BLK: if (t_ack_i) begin
          merged_q <= lane_merged;
          state_q  <= S_WR;
        end
        S_WR:    if (t_ack_i) state_q <= S_RESP;
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign t_req_o   = (state_q == S_RD) || (state_q == S_BLK) || (state_q == S_WR);
  assign t_we_o    = (state_q == S_BLK) || (state_q == S_WR);
  assign t_addr_o  = (state_q == S_BLK) ? BLK_ADDR : {op_addr_q[AW-1:2], 2'b00};
  assign t_wdata_o = (state_q == S_BLK) ? sl_q[SL_BLK] : merged_q;
  assign h_ready_o = (state_q == S_RESP);
  assign h_rdata_o = rdata_q;
endmodule

// File: rtl/rnb_bridge_chk.sv
module rnb_bridge_chk #(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] XFER_ADDR = AW'('h0C),
  parameter logic [AW-1:0] BLK_ADDR  = AW'('h04)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          h_req_i,
  input logic          h_we_i,
  input logic [1:0]    h_size_i,
  input logic [AW-1:0] h_addr_i,
  input logic          h_ready_o,
  input logic          t_req_o,
  input logic          t_we_o,
  input logic [AW-1:0] t_addr_o,
  input logic          t_ack_i,
  input logic          blk_vld_i
);
  logic h_xfer, h_cmd;
  assign h_xfer = (h_size_i == 2'd1) && (h_addr_i == XFER_ADDR);
  assign h_cmd  = (h_size_i == 2'd1) && (h_addr_i == (XFER_ADDR + AW'(2)));

  AST_TGT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_req_o |-> (t_addr_o[1:0] == 2'b00)); // R2

  AST_NO_WRITE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_req_o && t_we_o) |-> (h_req_i && h_we_i)); // R3

  AST_XFER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_req_i && h_we_i && h_xfer) |-> !(t_req_o && t_we_o)); // R6

  AST_BLK_BEFORE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_req_i && h_we_i && h_cmd && t_req_o && t_we_o && (t_addr_o == XFER_ADDR))
      |-> !blk_vld_i); // R8

  AST_TGT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_req_o && !t_ack_i) |=> (t_req_o && $stable(t_addr_o) && $stable(t_we_o))); // R10

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ready_o |=> !h_ready_o); // R10

  AST_TGT_UNDER_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_req_o |-> h_req_i); // R10

  AST_FLUSH_TO_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_req_o && t_we_o && h_cmd && blk_vld_i) |-> (t_addr_o == BLK_ADDR)); // R8
endmodule

bind rnb_bridge rnb_bridge_chk #(
  .AW(AW), .XFER_ADDR(XFER_ADDR), .BLK_ADDR(BLK_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .h_req_i   (h_req_i),
  .h_we_i    (h_we_i),
  .h_size_i  (h_size_i),
  .h_addr_i  (h_addr_i),
  .h_ready_o (h_ready_o),
  .t_req_o   (t_req_o),
  .t_we_o    (t_we_o),
  .t_addr_o  (t_addr_o),
  .t_ack_i   (t_ack_i),
  .blk_vld_i (blk_vld)
);

// File: tb/rnb_bridge_tb.sv
module rnb_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          h_req_i = 1'b0;
  logic          h_we_i = 1'b0;
  logic [1:0]    h_size_i = 2'd0;
  logic [AW-1:0] h_addr_i = '0;
  logic [31:0]   h_wdata_i = '0;
  logic [31:0]   h_rdata_o;
  logic          h_ready_o;
  logic          t_req_o, t_we_o;
  logic [AW-1:0] t_addr_o;
  logic [31:0]   t_wdata_o;
  logic [31:0]   t_rdata_i = '0;
  logic          t_ack_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rnb_bridge #(.AW(AW)) u_dut (.*);

  // target model: one-cycle registered acknowledge
  logic [31:0] mem [64];
  int          rd_tot = 0;
  int          wr_tot = 0;
  logic [7:0]  wlog_addr [64];
  logic [31:0] wlog_data [64];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      t_ack_i <= 1'b0;
    end else if (t_req_o && !t_ack_i) begin
      t_ack_i <= 1'b1;
      if (t_we_o) begin
        mem[t_addr_o[7:2]]      <= t_wdata_o;
        wlog_addr[wr_tot % 64]  <= t_addr_o;
        wlog_data[wr_tot % 64]  <= t_wdata_o;
        wr_tot                  <= wr_tot + 1;
      end else begin
        t_rdata_i <= mem[t_addr_o[7:2]];
        rd_tot    <= rd_tot + 1;
      end
    end else begin
      t_ack_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  int rd0, wr0;

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk_i);
    rd0 = rd_tot; wr0 = wr_tot;
    h_req_i = 1'b1; h_we_i = we; h_size_i = sz; h_addr_i = a; h_wdata_i = wd;
    do @(negedge clk_i); while (!h_ready_o);
    rd = h_rdata_o;
    h_req_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk(h_ready_o == 1'b0, "R1 ready in reset", 32'(h_ready_o), 0);
    chk(t_req_o == 1'b0, "R1 t_req in reset", 32'(t_req_o), 0);
    rst_ni = 1'b1;
    access(0, 2'd1, 8'h0C, 0, r);
    chk(rd_tot - rd0 == 1, "R1 xfer read goes to target", 32'(rd_tot - rd0), 1);
    chk(r == 0, "R1 xfer read value", r, 0);
    @(negedge clk_i);
    chk(h_ready_o == 1'b0, "R10 ready single pulse", 32'(h_ready_o), 0);
    chk(t_req_o == 1'b0, "R10 no target req when idle", 32'(t_req_o), 0);
  endtask

  task automatic t_full;
    logic [31:0] r;
    access(1, 2'd2, 8'h10, 32'hAABBCCDD, r);
    chk(wr_tot - wr0 == 1 && rd_tot == rd0, "R5 one write no read", 32'(wr_tot - wr0), 1);
    chk(mem[4] == 32'hAABBCCDD, "R5 dword written", mem[4], 32'hAABBCCDD);
  endtask

  task automatic t_read;
    logic [31:0] r;
    access(0, 2'd0, 8'h11, 0, r);
    chk(r == 32'h000000CC, "R3 byte lane 1", r, 32'hCC);
    chk(wr_tot == wr0, "R3 read makes no write", 32'(wr_tot - wr0), 0);
    access(0, 2'd0, 8'h13, 0, r);
    chk(r == 32'h000000AA, "R2 byte lane 3", r, 32'hAA);
    access(0, 2'd1, 8'h12, 0, r);
    chk(r == 32'h0000AABB, "R2 upper halfword", r, 32'hAABB);
    access(0, 2'd2, 8'h10, 0, r);
    chk(r == 32'hAABBCCDD, "R3 dword read", r, 32'hAABBCCDD);
  endtask

  task automatic t_rmw;
    logic [31:0] r;
    access(1, 2'd0, 8'h12, 32'h55, r);
    chk(rd_tot - rd0 == 1 && wr_tot - wr0 == 1, "R4 byte rmw counts", 32'(rd_tot - rd0), 1);
    chk(mem[4] == 32'hAA55CCDD, "R4 byte merge", mem[4], 32'hAA55CCDD);
    access(1, 2'd1, 8'h10, 32'h1234, r);
    chk(mem[4] == 32'hAA551234, "R4 halfword merge", mem[4], 32'hAA551234);
    chk(wlog_addr[wr0 % 64] == 8'h10, "R2 rmw aligned address", 32'(wlog_addr[wr0 % 64]), 32'h10);
  endtask

  task automatic t_xfer;
    logic [31:0] r;
    access(1, 2'd2, 8'h0C, 32'hDEAD0000, r);
    access(1, 2'd1, 8'h0C, 32'h0033, r);
    chk(rd_tot - rd0 == 1 && wr_tot == wr0, "R6 xfer fetch, no write", 32'(wr_tot - wr0), 0);
    chk(mem[3] == 32'hDEAD0000, "R6 target untouched", mem[3], 32'hDEAD0000);
    access(0, 2'd1, 8'h0C, 0, r);
    chk(r == 32'h0033 && rd_tot == rd0, "R6 xfer read from shadow", r, 32'h0033);
    access(0, 2'd2, 8'h0C, 0, r);
    chk(r == 32'hDEAD0000, "R9 dword read bypasses shadow", r, 32'hDEAD0000);
  endtask

  task automatic t_blk;
    logic [31:0] r;
    access(1, 2'd2, 8'h04, 32'h00070200, r);
    access(1, 2'd1, 8'h04, 32'h0040, r);
    chk(rd_tot - rd0 == 1 && wr_tot == wr0, "R7 first blk write fetches", 32'(rd_tot - rd0), 1);
    access(1, 2'd1, 8'h06, 32'h0008, r);
    chk(rd_tot == rd0 && wr_tot == wr0, "R7 second blk write in shadow", 32'(rd_tot - rd0), 0);
    chk(mem[1] == 32'h00070200, "R7 target untouched", mem[1], 32'h00070200);
    access(0, 2'd1, 8'h06, 0, r);
    chk(r == 32'h0008 && rd_tot == rd0, "R7 count from shadow", r, 32'h0008);
    access(0, 2'd1, 8'h04, 0, r);
    chk(r == 32'h0040, "R7 size from shadow", r, 32'h0040);
    access(0, 2'd2, 8'h04, 0, r);
    chk(r == 32'h00070200, "R9 dword read of blk", r, 32'h00070200);
  endtask

  task automatic t_cmd;
    logic [31:0] r;
    access(1, 2'd1, 8'h0E, 32'h113A, r);
    chk(wr_tot - wr0 == 2 && rd_tot == rd0, "R8 two writes no read", 32'(wr_tot - wr0), 2);
    chk(wlog_addr[wr0 % 64] == 8'h04, "R8 blk flushed first", 32'(wlog_addr[wr0 % 64]), 32'h04);
    chk(wlog_data[wr0 % 64] == 32'h00080040, "R8 blk flush data", wlog_data[wr0 % 64], 32'h00080040);
    chk(wlog_addr[(wr0 + 1) % 64] == 8'h0C, "R8 cmd second", 32'(wlog_addr[(wr0 + 1) % 64]), 32'h0C);
    chk(wlog_data[(wr0 + 1) % 64] == 32'h113A0033, "R8 cmd dword", wlog_data[(wr0 + 1) % 64], 32'h113A0033);
    access(0, 2'd1, 8'h0C, 0, r);
    chk(rd_tot - rd0 == 1 && r == 32'h0033, "R8 cmd shadow released", r, 32'h0033);
    access(0, 2'd1, 8'h06, 0, r);
    chk(rd_tot - rd0 == 1 && r == 32'h0008, "R8 blk shadow released", r, 32'h0008);
  endtask

  task automatic t_cmd_noblk;
    logic [31:0] r;
    access(1, 2'd1, 8'h0C, 32'h0011, r);
    access(1, 2'd1, 8'h0E, 32'h0022, r);
    chk(wr_tot - wr0 == 1, "R8 single write without blk", 32'(wr_tot - wr0), 1);
    chk(wlog_addr[wr0 % 64] == 8'h0C && wlog_data[wr0 % 64] == 32'h00220011,
        "R8 cmd-only dword", wlog_data[wr0 % 64], 32'h00220011);
  endtask

  task automatic t_bypass;
    logic [31:0] r;
    access(1, 2'd1, 8'h0C, 32'h0077, r);
    access(1, 2'd2, 8'h0C, 32'hCAFEF00D, r);
    chk(wr_tot - wr0 == 1 && mem[3] == 32'hCAFEF00D, "R5 dword write passes", mem[3], 32'hCAFEF00D);
    access(0, 2'd1, 8'h0C, 0, r);
    chk(r == 32'h0077 && rd_tot == rd0, "R5 shadow kept", r, 32'h0077);
    access(1, 2'd1, 8'h0E, 32'h0001, r);
    chk(mem[3] == 32'h00010077, "R8 cmd merges with shadow", mem[3], 32'h00010077);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_full();
    t_read();
    t_rmw();
    t_xfer();
    t_blk();
    t_cmd();
    t_cmd_noblk();
    t_bypass();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule